// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bus-facing half of a software-paced I2C master. Software prepares one byte and its intent (open with a START, close with a STOP, or neither) and then strobes `go`. The engine places the byte on the wire, handles the ninth acknowledge clock, and afterwards parks the bus with SCL held low until the next strobe. The flags that carry the START and STOP intent are plain level inputs. The engine samples them but never changes them, so software must drop them itself once they have served.

A transaction opens with a START and an address byte. Bit 0 of that byte selects the direction of the data bytes that follow: 1 means the master reads and 0 means it writes. Write bytes report the slave's acknowledge in `ack_err`. Read bytes land in `rx_data`, and the engine answers each one with ACK, or with NAK when `nak_sel` is set. To end a read, software strobes the last byte with `nak_sel` and `stop_req` both set. SCL runs from a fixed divider. Each bit lasts four equal quarters, each `QTR_CYC` clock cycles long: two quarters low, then two quarters high.

Top module: `i2cm_byte_engine`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `bus_owned`, `tx_empty`, `rx_full`, `ack_err` and `rx_data` are all 0, so both bus lines are released.
- R2: A `go` strobe is taken only while `busy` is 0. Taking it sets `busy` and clears `tx_empty` and `rx_full`. A strobe, or a change of `tx_byte`, while `busy` is 1 has no effect on the byte in flight or on its timing.
- R3: A START precedes the byte when `start_req` is 1 at the strobe, or when the bus is not owned. It is a repeated START if the bus is already owned. SDA falls while SCL is released. The byte after a START is an address, and its bit 0 (1 = read) selects the direction of every following data byte until the next START.
- R4: With `start_req` and `stop_req` both 0 on an owned bus, the byte is sent with no bus condition, taking 36 quarters.
- R5: With `stop_req` at 1, a STOP (SDA rising while SCL is released) follows the acknowledge clock, whatever `start_req` holds. Afterwards `bus_owned` is 0 and both lines are released.
- R6: `busy` falls, and the status flag rises, exactly (4·S + 36 + 4·P)·`QTR_CYC` cycles after the accepting clock edge. S is 1 when a START is sent and P is 1 when a STOP is sent.
- R7: Written bytes go out MSB first. Inside a bit, SDA changes only while SCL is driven low. The acknowledge is sampled at the end of the ninth SCL high phase, and `ack_err` is set to the sampled level (1 = NAK) after each written byte.
- R8: While the bus is owned and `busy` is 0, SCL is driven low.
- R9: A read byte is shifted in MSB first and appears on `rx_data`. During the ninth clock the engine drives SDA low (ACK) when `nak_sel` was 0 at the strobe, and releases it (NAK) when `nak_sel` was 1.
- R10: `tx_empty` is set when a written byte (address bytes included) completes, and `rx_full` is set when a read byte completes. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Transfer-byte strobe |
| start_req | input | 1 | Open with START or repeated START |
| stop_req | input | 1 | Close with STOP after this byte |
| nak_sel | input | 1 | On a read byte, answer NAK instead of ACK |
| tx_byte | input | DATA_W | Byte to write, or address byte |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Byte in progress |
| bus_owned | output | 1 | Bus held between START and STOP |
| tx_empty | output | 1 | Written byte completed |
| rx_full | output | 1 | Read byte completed |
| rx_data | output | DATA_W | Last read byte |
| ack_err | output | 1 | Last written byte was NAKed |

## Verification
Every result of a byte comes due at one known edge: (4·S + 36 + 4·P)·`QTR_CYC` cycles after the edge that takes the strobe. The bench computes that count from the flags it drives. It samples `busy` at mid-cycle one cycle before that edge, expecting 1, and at mid-cycle just after it, expecting 0. At that second sample it also checks the status flags, `rx_data`, `ack_err`, bus ownership and the line levels. A behavioural slave on the wired-AND bus records the bytes, acknowledges and conditions it sees. Its records are settled by the time the bench compares them with the values it computed.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C master byte engine.
// Assumes: nothing beyond IEEE 1800-2017.
package i2cm_pkg;

    // Bus sequencing phase of the engine.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,   // bus not owned, both lines released
        PH_HOLD  = 3'd1,   // bus owned, SCL parked low between bytes
        PH_START = 3'd2,   // START or repeated START
        PH_BITS  = 3'd3,   // data bits plus the acknowledge clock
        PH_STOP  = 3'd4    // STOP
    } phase_t;

    // Number of quarter periods in one SCL bit.
    localparam int QUARTERS = 4;

endpackage

// File: rtl/i2cm_qtick.sv
// Quarter-period tick generator.
// Counts QTR_CYC cycles while run is high and pulses tick on the last one.
// Assumes: QTR_CYC >= 2. The count restarts from zero whenever run is low.
module i2cm_qtick #(
    parameter int QTR_CYC = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYC > 2) ? $clog2(QTR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt;

    // Divider counter: held at zero when idle, wraps at the end of each quarter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/i2cm_shifter.sv
// Byte shift register shared by write and read.
// Loads the outgoing byte, presents its MSB, and shifts the sensed bus bit
// in at the LSB, so after a full byte it holds what was on the wire.
// Assumes: load and shift are never high in the same cycle.
module i2cm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic         msb,
    output logic [W-1:0] value
);
    logic [W-1:0] sh;

    // Shift register: load on accept, shift left by one bit on each bit end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= load_val;
        end else if (shift) begin
            sh <= {sh[W-2:0], in_bit};
        end
    end

    assign msb   = sh[W-1];
    assign value = sh;

endmodule

// File: rtl/i2cm_seq.sv
// Bus sequencer: walks the START, bits, acknowledge and STOP phases
// quarter by quarter and decodes the open-drain drive levels.
// Assumes: launch only arrives in PH_IDLE or PH_HOLD, and a launch with
// with_start low only arrives while the bus is owned.
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch,
    input  logic   with_start,
    input  logic   with_stop,
    input  logic   rx_byte,
    input  logic   nak_sel,
    input  logic   tick,
    input  logic   data_msb,
    output phase_t phase,
    output logic   run,
    output logic   shift_en,
    output logic   ack_cap,
    output logic   byte_done,
    output logic   done_rx,
    output logic   bus_owned,
    output logic   scl_oe,
    output logic   sda_oe
);
    localparam int BW = $clog2(DATA_W + 1);
    localparam logic [BW-1:0] ACK_SLOT = BW'(DATA_W);
    localparam logic [1:0] LAST_Q = 2'(QUARTERS - 1);

    logic [1:0]    qtr;
    logic [BW-1:0] bit_idx;
    logic          lat_stop;
    logic          lat_rx;
    logic          lat_nak;
    logic          lat_resume;
    logic          last_q;
    logic          in_ack;

    assign last_q = (qtr == LAST_Q);
    assign in_ack = (bit_idx == ACK_SLOT);

    // Phase, quarter and bit counters, plus the per-byte intent latched at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            qtr        <= '0;
            bit_idx    <= '0;
            lat_stop   <= 1'b0;
            lat_rx     <= 1'b0;
            lat_nak    <= 1'b0;
            lat_resume <= 1'b0;
            bus_owned  <= 1'b0;
        end else if (launch) begin
            phase      <= with_start ? PH_START : PH_BITS;
            qtr        <= '0;
            bit_idx    <= '0;
            lat_stop   <= with_stop;
            lat_rx     <= rx_byte;
            lat_nak    <= nak_sel;
            lat_resume <= bus_owned;
            bus_owned  <= 1'b1;
        end else if (tick) begin
            qtr <= qtr + 1'b1;
            if (last_q) begin
                case (phase)
                    PH_START: begin
                        phase   <= PH_BITS;
                        bit_idx <= '0;
                    end
                    PH_BITS: begin
                        if (in_ack) begin
                            phase <= lat_stop ? PH_STOP : PH_HOLD;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        phase     <= PH_IDLE;
                        bus_owned <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Event strobes for the divider, shifter and status logic.
    always_comb begin
        run       = (phase == PH_START) || (phase == PH_BITS) || (phase == PH_STOP);
        shift_en  = tick && last_q && (phase == PH_BITS) && !in_ack;
        ack_cap   = tick && last_q && (phase == PH_BITS) && in_ack && !lat_rx;
        byte_done = tick && last_q &&
                    (((phase == PH_BITS) && in_ack && !lat_stop) || (phase == PH_STOP));
        done_rx   = lat_rx;
    end

    // Open-drain drive levels per phase and quarter (1 pulls the line low).
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (phase)
            PH_HOLD: begin
                scl_oe = 1'b1;
            end
            PH_START: begin
                case (qtr)
                    2'd0:    scl_oe = lat_resume;
                    2'd1:    scl_oe = 1'b0;
                    default: sda_oe = 1'b1;
                endcase
            end
            PH_BITS: begin
                scl_oe = !qtr[1];
                if (in_ack) begin
                    sda_oe = lat_rx && !lat_nak;
                end else begin
                    sda_oe = !lat_rx && !data_msb;
                end
            end
            PH_STOP: begin
                scl_oe = !qtr[1];
                sda_oe = (qtr != LAST_Q);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2cm_byte_engine.sv
// I2C master byte engine, top level.
// Takes one byte per go strobe, works out whether a START is needed,
// tracks the read/write direction chosen by the address byte, and keeps
// the busy, status, read-data and acknowledge-error outputs.
// Assumes: SCL is not stretched by slaves; there is one master on the bus.
module i2cm_byte_engine
    import i2cm_pkg::*;
#(
    parameter int QTR_CYC = 63,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              nak_sel,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              bus_owned,
    output logic              tx_empty,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              ack_err
);
    phase_t            phase;
    logic              launch;
    logic              eff_start;
    logic              rx_mode;
    logic              rx_byte;
    logic              tick;
    logic              run;
    logic              shift_en;
    logic              ack_cap;
    logic              byte_done;
    logic              done_rx;
    logic              data_msb;
    logic [DATA_W-1:0] sh_value;

    // Accept decode: a START is forced when the bus is not yet owned.
    always_comb begin
        launch    = go && !busy;
        eff_start = start_req || !bus_owned;
        rx_byte   = rx_mode && !eff_start;
    end

    // Busy, status flags, read data, acknowledge error and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            tx_empty <= 1'b0;
            rx_full  <= 1'b0;
            rx_data  <= '0;
            ack_err  <= 1'b0;
            rx_mode  <= 1'b0;
        end else begin
            if (launch) begin
                busy     <= 1'b1;
                tx_empty <= 1'b0;
                rx_full  <= 1'b0;
                if (eff_start) begin
                    rx_mode <= tx_byte[0];
                end
            end else if (byte_done) begin
                busy <= 1'b0;
                if (done_rx) begin
                    rx_full <= 1'b1;
                    rx_data <= sh_value;
                end else begin
                    tx_empty <= 1'b1;
                end
            end
            if (ack_cap) begin
                ack_err <= sda_i;
            end
        end
    end

    i2cm_qtick #(
        .QTR_CYC (QTR_CYC)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    i2cm_shifter #(
        .W (DATA_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (tx_byte),
        .shift    (shift_en),
        .in_bit   (sda_i),
        .msb      (data_msb),
        .value    (sh_value)
    );

    i2cm_seq #(
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .with_start (eff_start),
        .with_stop  (stop_req),
        .rx_byte    (rx_byte),
        .nak_sel    (nak_sel),
        .tick       (tick),
        .data_msb   (data_msb),
        .phase      (phase),
        .run        (run),
        .shift_en   (shift_en),
        .ack_cap    (ack_cap),
        .byte_done  (byte_done),
        .done_rx    (done_rx),
        .bus_owned  (bus_owned),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe)
    );

endmodule

// File: rtl/i2cm_checks.sv
// Property checker for i2cm_byte_engine, attached with bind below.
// Assumes: the top-level signal named phase carries the sequencer phase.
module i2cm_checks
    import i2cm_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   go,
    input logic   busy,
    input logic   bus_owned,
    input logic   scl_oe,
    input logic   sda_oe,
    input logic   tx_empty,
    input logic   rx_full,
    input phase_t phase
);
    // R2: an accepted strobe makes the engine busy on the next cycle.
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);

    // R2: an accepted strobe clears both status flags.
    a_r2_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> (!tx_empty && !rx_full));

    // R3: in START, SDA is pulled low only while SCL is released.
    a_r3_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && phase == PH_START) |-> !scl_oe);

    // R5: with the bus neither owned nor busy, both lines are released.
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_owned && !busy) |-> (!scl_oe && !sda_oe));

    // R6: the end of a byte always comes with a status flag.
    a_r6_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tx_empty || rx_full));

    // R7: inside the bit phase, SDA stays put while SCL stays released.
    a_r7_sda_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BITS && $past(phase) == PH_BITS && !scl_oe && !$past(scl_oe))
            |-> $stable(sda_oe));

    // R8: an owned, idle bus has SCL parked low.
    a_r8_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_owned && !busy) |-> scl_oe);

    // R10: the two status flags are never set together.
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_empty && rx_full));

endmodule

bind i2cm_byte_engine i2cm_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .busy      (busy),
    .bus_owned (bus_owned),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .phase     (phase)
);

// File: tb/sim_i2cm_byte_engine.sv
// Bench for i2cm_byte_engine: directed corner cases plus seeded random
// transactions against a behavioural slave on a wired-AND bus.
module sim_i2cm_byte_engine;
    localparam int QC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go = 1'b0;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       nak_sel = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_i;
    logic       scl_oe, sda_oe, busy, bus_owned, tx_empty, rx_full, ack_err;
    logic [7:0] rx_data;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference state the bench keeps for itself.
    bit m_owned = 1'b0;
    bit m_rx = 1'b0;
    int m_idx = 0;
    int exp_starts = 0;
    int exp_stops = 0;

    // Behavioural slave state.
    logic       s_pull = 1'b0;
    logic       s_nak = 1'b0;
    logic       p_scl = 1'b1;
    logic       p_sda = 1'b1;
    int         s_cnt = 0;
    bit         s_addr = 1'b0;
    bit         s_rd = 1'b0;
    logic [7:0] s_sh = 8'h00;
    logic [7:0] s_tx = 8'h00;
    int         s_idx = 0;
    logic [7:0] slv_rx = 8'h00;
    logic       slv_mack = 1'b0;
    int         slv_starts = 0;
    int         slv_stops = 0;

    logic bscl, bsda;
    assign bscl  = !scl_oe;
    assign bsda  = !(sda_oe || s_pull);
    assign sda_i = bsda;

    always #5 clk = !clk;

    i2cm_byte_engine #(.QTR_CYC(QC), .DATA_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .start_req(start_req),
        .stop_req(stop_req), .nak_sel(nak_sel), .tx_byte(tx_byte),
        .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .bus_owned(bus_owned), .tx_empty(tx_empty), .rx_full(rx_full),
        .rx_data(rx_data), .ack_err(ack_err)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'h5A ^ 8'(k * 29);
    endfunction

    function automatic int byte_cycles(input bit with_s, input bit with_p);
        return ((with_s ? 4 : 0) + 36 + (with_p ? 4 : 0)) * QC;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Slave model: watches the bus mid-cycle, acks writes, serves reads.
    always @(negedge clk) begin
        logic cs, cd;
        cs = bscl;
        cd = bsda;
        if (!rst_n) begin
            s_pull = 1'b0; s_cnt = 0; s_addr = 1'b0; s_rd = 1'b0;
        end else if (p_scl && cs && p_sda && !cd) begin
            s_cnt = 0; s_addr = 1'b1; s_rd = 1'b0; s_pull = 1'b0;
            slv_starts++;
        end else if (p_scl && cs && !p_sda && cd) begin
            s_cnt = 0; s_rd = 1'b0; s_pull = 1'b0;
            slv_stops++;
        end else if (!p_scl && cs) begin
            if (s_cnt < 8) begin
                s_sh = {s_sh[6:0], cd};
                s_cnt++;
                if (s_cnt == 8 && !s_rd) slv_rx = s_sh;
            end else if (s_cnt == 8) begin
                slv_mack = cd;
                s_cnt = 9;
            end
        end else if (p_scl && !cs) begin
            if (s_cnt == 8) begin
                s_pull = s_rd ? 1'b0 : !s_nak;
            end else if (s_cnt == 9) begin
                s_cnt = 0;
                if (s_addr) begin
                    s_addr = 1'b0;
                    s_rd = s_sh[0];
                end else if (s_rd && slv_mack) begin
                    s_rd = 1'b0;
                end
                if (s_rd) begin
                    s_tx = pat(s_idx);
                    s_idx++;
                    s_pull = !s_tx[7];
                end else begin
                    s_pull = 1'b0;
                end
            end else if (s_cnt > 0 && s_rd) begin
                s_pull = !s_tx[7 - s_cnt];
            end
        end
        p_scl = cs;
        p_sda = cd;
    end

    // One byte: drive the strobe, check exact completion timing and results.
    task automatic xfer(input bit st, input bit sp, input bit nk,
                        input logic [7:0] d, input bit poke);
        bit eff_s, exp_rx;
        int n;
        eff_s  = st || !m_owned;
        exp_rx = eff_s ? 1'b0 : m_rx;
        n = byte_cycles(eff_s, sp);
        @(negedge clk);
        start_req = st; stop_req = sp; nak_sel = nk; tx_byte = d; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
        chk(!tx_empty && !rx_full, "R2", "flags cleared on accept", {tx_empty, rx_full}, 0);
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            go      = poke && (i == n / 2);
            tx_byte = (poke && (i == n / 2)) ? ~d : d;
        end
        chk(busy == 1'b1, "R6", "busy one cycle before due", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R6", "busy cleared when due", busy, 0);
        if (eff_s) begin
            m_rx = d[0];
            exp_starts++;
        end
        if (sp) exp_stops++;
        m_owned = !sp;
        if (exp_rx) begin
            chk(rx_full && !tx_empty, "R10", "read flags", {rx_full, tx_empty}, 2);
            chk(rx_data == pat(m_idx), "R9", "read data MSB first", rx_data, pat(m_idx));
            chk(slv_mack == nk, "R9", "master ack level", slv_mack, nk);
            m_idx++;
        end else begin
            chk(tx_empty && !rx_full, "R10", "write flags", {tx_empty, rx_full}, 2);
            chk(slv_rx == d, "R7", "byte seen by slave", slv_rx, d);
            chk(ack_err == s_nak, "R7", "ack_err level", ack_err, s_nak);
        end
        chk(slv_starts == exp_starts, "R3", "START count", slv_starts, exp_starts);
        chk(slv_stops == exp_stops, "R5", "STOP count", slv_stops, exp_stops);
        chk(bus_owned == m_owned, "R5", "bus_owned", bus_owned, m_owned);
        if (sp) begin
            chk(!scl_oe && !sda_oe, "R5", "lines released after STOP", {scl_oe, sda_oe}, 0);
        end else begin
            chk(scl_oe == 1'b1, "R8", "SCL held low after byte", scl_oe, 1);
        end
    endtask

    // Idle gap; the owned bus must keep SCL low throughout.
    task automatic gap(input int cyc);
        for (int i = 0; i < cyc; i++) @(negedge clk);
        if (m_owned) chk(scl_oe == 1'b1, "R8", "SCL low while waiting", scl_oe, 1);
        chk(busy == 1'b0, "R2", "no spontaneous start", busy, 0);
    endtask

    initial begin
        int nw, nr;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!scl_oe && !sda_oe, "R1", "lines released", {scl_oe, sda_oe}, 0);
        chk(!busy && !bus_owned, "R1", "busy/owned", {busy, bus_owned}, 0);
        chk(!tx_empty && !rx_full && !ack_err, "R1", "status", {tx_empty, rx_full, ack_err}, 0);
        chk(rx_data == 8'h00, "R1", "rx_data", rx_data, 0);

        // R3: no start flag on an idle bus still opens with START
        xfer(1'b0, 1'b0, 1'b0, 8'hA0, 1'b0);
        gap(7);
        // R4: streamed writes with no condition
        for (int k = 0; k < 4; k++) begin
            xfer(1'b0, 1'b0, 1'b0, 8'($urandom), 1'b0);
            gap(1 + int'($urandom % 9));
        end
        // R7: slave NAK recorded, then cleared by the next ACK
        s_nak = 1'b1;
        xfer(1'b0, 1'b0, 1'b0, 8'h3C, 1'b0);
        s_nak = 1'b0;
        xfer(1'b0, 1'b0, 1'b0, 8'hC3, 1'b0);
        // R2: strobe and data change while busy are ignored
        xfer(1'b0, 1'b0, 1'b0, 8'h96, 1'b1);
        // R5: repeated START and STOP on one byte
        xfer(1'b1, 1'b1, 1'b0, 8'h42, 1'b0);
        gap(5);
        // R9: read with ACKs, last one NAK plus STOP
        xfer(1'b1, 1'b0, 1'b0, 8'hA1, 1'b0);
        xfer(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        xfer(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        xfer(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        gap(3);

        // Random transactions: write burst, repeated START, read burst.
        for (int t = 0; t < 6; t++) begin
            xfer(1'b1, 1'b0, 1'b0, {7'($urandom), 1'b0}, 1'b0);
            nw = 1 + int'($urandom % 4);
            for (int k = 0; k < nw; k++) begin
                xfer(1'b0, 1'b0, 1'b0, 8'($urandom), 1'b0);
                gap(int'($urandom % 6));
            end
            xfer(1'b1, 1'b0, 1'b0, {7'($urandom), 1'b1}, 1'b0);
            nr = 1 + int'($urandom % 3);
            for (int k = 0; k < nr; k++) begin
                xfer(1'b0, 1'b0, 1'b0, 8'($urandom), 1'b0);
            end
            xfer(1'b0, 1'b1, 1'b1, 8'($urandom), 1'b0);
            gap(2 + int'($urandom % 5));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule